// File: doc/BRIEF.md
# Dual-Clock Mailbox Bypass with Port Command Decode

This block sits beside a one-way FIFO that runs between two independently clocked ports. It adds two single-word mailboxes that carry traffic around the FIFO. The forward mailbox is loaded from port A and emptied at port B. The return mailbox is loaded from port B and emptied at port A.

Each port has four control inputs: an active-low select, a direction (1 = write), an enable and a mailbox select. One decoder per port turns these into a FIFO strobe, a mailbox load, a mailbox fetch or nothing. The same inputs also decide whether the port's read bus is driven. The FIFO array is not part of this block. It receives a write strobe with data from port A and a read strobe from port B, and it returns its output register on `fifo_q`.

Each mailbox has one status flag, held high while the mailbox is free and low while a word is waiting. The flag is visible in both clock domains. A load pulls the flag low at once on the writer side. The pending state crosses to the reader through a two-flop synchronizer. A fetch by the reader frees the mailbox on the reader side at that edge. The freed state then returns to the writer through a second synchronizer and a four-phase handshake.

Top module: `mbx_bypass`

## Requirements
- R1: While a port's select `*_cs_n` is 1, that port's `*_oe` is 0, its bus reads 0, its FIFO strobe is 0, and an edge changes no mailbox state.
- R2: Port A with select low, direction 1, enable 1 and mailbox select 0 raises `fifo_wr` for that cycle, with `fifo_wdata` equal to `a_din`. A port with direction 1 has `*_oe` = 0.
- R3: A load into a free mailbox (writer port: direction 1, enable 1, mailbox select 1) stores the input word. The writer-side flag reads 0 after that edge, and the reader-side flag falls within three reader clock edges.
- R4: Port B with select low and direction 0 has `b_oe` = 1. `b_dout` shows `fifo_q` when `b_mbox` = 0 and the forward mailbox word when `b_mbox` = 1.
- R5: Port B with select low, direction 0, enable 1 and mailbox select 0 raises `fifo_rd` for that cycle.
- R6: A fetch at port B (direction 0, enable 1, mailbox select 1) while the forward mailbox is pending makes `mb1_idle_b` read 1 after that edge. `mb1_idle_a` returns to 1 within twelve port A edges. A reader-side flag stays 0 until such a fetch.
- R7: The return mailbox works in the same way in the opposite direction: loaded at port B, fetched at port A, with flags `mb2_idle_b` and `mb2_idle_a`. Port A with select low and direction 0 drives the return mailbox word on `a_dout`.
- R8: With enable 0, no FIFO strobe is raised and no mailbox load or fetch takes place, whatever the other controls are.
- R9: A load into a mailbox whose writer-side flag is 0 is ignored. The stored word and the flag are unchanged.
- R10: After reset, all four mailbox flags read 1 and both FIFO strobes are 0 while the select inputs are high.
- R11: A fetch from a mailbox that is not pending has no effect. Both of its flags stay 1.
- R12: Port A with direction 0 and mailbox select 0, and port B with direction 1 and mailbox select 0, raise no FIFO strobe even with enable 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| rst_a | input | 1 | Synchronous active-high reset, clk_a domain |
| a_cs_n | input | 1 | Port A select, active low |
| a_wr_dir | input | 1 | Port A direction, 1 = write |
| a_en | input | 1 | Port A enable |
| a_mbox | input | 1 | Port A mailbox select |
| a_din | input | W | Port A write data |
| a_dout | output | W | Port A read bus (return mailbox) |
| a_oe | output | 1 | Port A bus drive enable |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_wdata | output | W | FIFO write data |
| mb1_idle_a | output | 1 | Forward mailbox free, writer view |
| mb2_idle_a | output | 1 | Return mailbox free, reader view |
| clk_b | input | 1 | Port B clock |
| rst_b | input | 1 | Synchronous active-high reset, clk_b domain |
| b_cs_n | input | 1 | Port B select, active low |
| b_wr_dir | input | 1 | Port B direction, 1 = write |
| b_en | input | 1 | Port B enable |
| b_mbox | input | 1 | Port B mailbox select |
| b_din | input | W | Port B write data |
| fifo_q | input | W | FIFO output register |
| b_dout | output | W | Port B read bus |
| b_oe | output | 1 | Port B bus drive enable |
| fifo_rd | output | 1 | FIFO read strobe |
| mb1_idle_b | output | 1 | Forward mailbox free, reader view |
| mb2_idle_b | output | 1 | Return mailbox free, writer view |

## Verification
The bench loads a mailbox and then loads it again before the reader fetches. A design that let the second load through would deliver the later word, which the scoreboard flags as a mismatch with the queued value. The bench fetches from an empty mailbox, where a decoder that set the acknowledge anyway would leave a stale acknowledge that swallows the next real transfer. It also tries every unmapped control combination and both disabled cases, with enable low and with select high, where a loose decode would raise a stray FIFO strobe. Finally, it reloads each mailbox after a full round trip, so a handshake that never returns to idle shows up as a timeout on the writer-side flag.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef enum logic [1:0] {
    OP_NONE    = 2'd0,
    OP_FIFO    = 2'd1,
    OP_MAIL_WR = 2'd2,
    OP_MAIL_RD = 2'd3
  } port_op_t;
endpackage

// File: rtl/mbx_sync.sv
module mbx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  localparam int N = (STAGES < 2) ? 2 : STAGES;
  logic [N-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[N-2:0], d};
  end

  assign q = chain[N-1];
endmodule

// File: rtl/mbx_port_decode.sv
module mbx_port_decode
  import mbx_pkg::*;
#(
  parameter bit FIFO_ON_WRITE = 1'b1
) (
  input  logic     cs_n,
  input  logic     wr_dir,
  input  logic     en,
  input  logic     mbox,
  output port_op_t op,
  output logic     oe
);
  logic act;
  assign act = !cs_n && en;
  assign oe  = !cs_n && !wr_dir;

  always_comb begin
    op = OP_NONE;
    if (act) begin
      if (mbox) op = wr_dir ? OP_MAIL_WR : OP_MAIL_RD;
      else if (wr_dir == FIFO_ON_WRITE) op = OP_FIFO;
    end
  end
endmodule

// File: rtl/mbx_channel.sv
module mbx_channel #(
  parameter int W          = 36,
  parameter int SYNC_DEPTH = 2
) (
  input  logic         wclk,
  input  logic         wrst,
  input  logic         load,
  input  logic [W-1:0] wdata,
  output logic         idle_w,
  input  logic         rclk,
  input  logic         rrst,
  input  logic         fetch,
  output logic         idle_r,
  output logic [W-1:0] word
);
  logic req_w, ack_w_s;
  logic ack_r, req_r_s;
  logic pending_r;

  mbx_sync #(.STAGES(SYNC_DEPTH)) u_req_sync (
    .clk(rclk), .rst(rrst), .d(req_w), .q(req_r_s));
  mbx_sync #(.STAGES(SYNC_DEPTH)) u_ack_sync (
    .clk(wclk), .rst(wrst), .d(ack_r), .q(ack_w_s));

  assign idle_w = !req_w && !ack_w_s;

  always_ff @(posedge wclk) begin
    if (wrst) begin
      req_w <= 1'b0;
      word  <= '0;
    end else if (load && idle_w) begin
      req_w <= 1'b1;
      word  <= wdata;
    end else if (ack_w_s) begin
      req_w <= 1'b0;
    end
  end

  assign pending_r = req_r_s && !ack_r;
  assign idle_r    = !pending_r;

  always_ff @(posedge rclk) begin
    if (rrst)                   ack_r <= 1'b0;
    else if (fetch && pending_r) ack_r <= 1'b1;
    else if (!req_r_s)          ack_r <= 1'b0;
  end
endmodule

// File: rtl/mbx_bypass.sv
module mbx_bypass
  import mbx_pkg::*;
#(
  parameter int W          = 36,
  parameter int SYNC_DEPTH = 2
) (
  input  logic         clk_a,
  input  logic         rst_a,
  input  logic         a_cs_n,
  input  logic         a_wr_dir,
  input  logic         a_en,
  input  logic         a_mbox,
  input  logic [W-1:0] a_din,
  output logic [W-1:0] a_dout,
  output logic         a_oe,
  output logic         fifo_wr,
  output logic [W-1:0] fifo_wdata,
  output logic         mb1_idle_a,
  output logic         mb2_idle_a,
  input  logic         clk_b,
  input  logic         rst_b,
  input  logic         b_cs_n,
  input  logic         b_wr_dir,
  input  logic         b_en,
  input  logic         b_mbox,
  input  logic [W-1:0] b_din,
  input  logic [W-1:0] fifo_q,
  output logic [W-1:0] b_dout,
  output logic         b_oe,
  output logic         fifo_rd,
  output logic         mb1_idle_b,
  output logic         mb2_idle_b
);
  port_op_t op_a, op_b;
  logic [W-1:0] mail1_q, mail2_q;

  mbx_port_decode #(.FIFO_ON_WRITE(1'b1)) u_dec_a (
    .cs_n(a_cs_n), .wr_dir(a_wr_dir), .en(a_en), .mbox(a_mbox),
    .op(op_a), .oe(a_oe));

  mbx_port_decode #(.FIFO_ON_WRITE(1'b0)) u_dec_b (
    .cs_n(b_cs_n), .wr_dir(b_wr_dir), .en(b_en), .mbox(b_mbox),
    .op(op_b), .oe(b_oe));

  mbx_channel #(.W(W), .SYNC_DEPTH(SYNC_DEPTH)) u_fwd (
    .wclk(clk_a), .wrst(rst_a), .load(op_a == OP_MAIL_WR), .wdata(a_din),
    .idle_w(mb1_idle_a),
    .rclk(clk_b), .rrst(rst_b), .fetch(op_b == OP_MAIL_RD),
    .idle_r(mb1_idle_b), .word(mail1_q));

  mbx_channel #(.W(W), .SYNC_DEPTH(SYNC_DEPTH)) u_ret (
    .wclk(clk_b), .wrst(rst_b), .load(op_b == OP_MAIL_WR), .wdata(b_din),
    .idle_w(mb2_idle_b),
    .rclk(clk_a), .rrst(rst_a), .fetch(op_a == OP_MAIL_RD),
    .idle_r(mb2_idle_a), .word(mail2_q));

  assign fifo_wr    = (op_a == OP_FIFO);
  assign fifo_wdata = a_din;
  assign fifo_rd    = (op_b == OP_FIFO);

  assign a_dout = a_oe ? mail2_q : '0;
  assign b_dout = !b_oe ? '0 : (b_mbox ? mail1_q : fifo_q);
endmodule

// File: rtl/mbx_bypass_chk.sv
module mbx_bypass_chk #(
  parameter int W = 36
) (
  input logic         clk_a,
  input logic         rst_a,
  input logic         a_cs_n,
  input logic         a_wr_dir,
  input logic         a_en,
  input logic         a_mbox,
  input logic         a_oe,
  input logic         fifo_wr,
  input logic         mb1_idle_a,
  input logic         clk_b,
  input logic         rst_b,
  input logic         b_cs_n,
  input logic         b_wr_dir,
  input logic         b_en,
  input logic         b_mbox,
  input logic         fifo_rd,
  input logic         mb1_idle_b,
  input logic [W-1:0] mail1_q
);
  logic a_load, b_fetch;
  assign a_load  = !a_cs_n && a_wr_dir && a_en && a_mbox;
  assign b_fetch = !b_cs_n && !b_wr_dir && b_en && b_mbox;

  // R1
  cs_quiet_a_chk: assert property (@(posedge clk_a) disable iff (rst_a)
    a_cs_n |-> (!a_oe && !fifo_wr));

  // R8
  en_low_b_chk: assert property (@(posedge clk_b) disable iff (rst_b)
    !b_en |-> !fifo_rd);

  // R3
  load_takes_chk: assert property (@(posedge clk_a) disable iff (rst_a)
    (a_load && mb1_idle_a) |=> !mb1_idle_a);

  // R9
  busy_load_ignored_chk: assert property (@(posedge clk_a) disable iff (rst_a)
    (a_load && !mb1_idle_a) |=> ($stable(mail1_q) && !mb1_idle_a));

  // R6
  fetch_frees_chk: assert property (@(posedge clk_b) disable iff (rst_b)
    (b_fetch && !mb1_idle_b) |=> mb1_idle_b);

  // R6
  pending_holds_chk: assert property (@(posedge clk_b) disable iff (rst_b)
    (!b_fetch && !mb1_idle_b) |=> !mb1_idle_b);

  // R10
  reset_idle_chk: assert property (@(posedge clk_a)
    rst_a |=> mb1_idle_a);
endmodule

bind mbx_bypass mbx_bypass_chk #(.W(W)) u_chk (
  .clk_a(clk_a), .rst_a(rst_a), .a_cs_n(a_cs_n), .a_wr_dir(a_wr_dir),
  .a_en(a_en), .a_mbox(a_mbox), .a_oe(a_oe), .fifo_wr(fifo_wr),
  .mb1_idle_a(mb1_idle_a),
  .clk_b(clk_b), .rst_b(rst_b), .b_cs_n(b_cs_n), .b_wr_dir(b_wr_dir),
  .b_en(b_en), .b_mbox(b_mbox), .fifo_rd(fifo_rd),
  .mb1_idle_b(mb1_idle_b), .mail1_q(mail1_q));

// File: tb/sim_mbx_bypass.sv
module sim_mbx_bypass;
  localparam int W        = 36;
  localparam int PERIOD_A = 10;
  localparam int PERIOD_B = 14;
  localparam int WATCHDOG = 50000;

  logic clk_a = 1'b0, clk_b = 1'b0;
  logic rst_a, rst_b;
  logic a_cs_n, a_wr_dir, a_en, a_mbox;
  logic b_cs_n, b_wr_dir, b_en, b_mbox;
  logic [W-1:0] a_din, b_din, fifo_q;
  logic [W-1:0] a_dout, b_dout, fifo_wdata;
  logic a_oe, b_oe, fifo_wr, fifo_rd;
  logic mb1_idle_a, mb1_idle_b, mb2_idle_a, mb2_idle_b;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [W-1:0] exp_m1[$];
  logic [W-1:0] exp_m2[$];

  always #(PERIOD_A/2) clk_a = ~clk_a;
  always #(PERIOD_B/2) clk_b = ~clk_b;

  mbx_bypass #(.W(W)) u0 (
    .clk_a(clk_a), .rst_a(rst_a), .a_cs_n(a_cs_n), .a_wr_dir(a_wr_dir),
    .a_en(a_en), .a_mbox(a_mbox), .a_din(a_din), .a_dout(a_dout),
    .a_oe(a_oe), .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata),
    .mb1_idle_a(mb1_idle_a), .mb2_idle_a(mb2_idle_a),
    .clk_b(clk_b), .rst_b(rst_b), .b_cs_n(b_cs_n), .b_wr_dir(b_wr_dir),
    .b_en(b_en), .b_mbox(b_mbox), .b_din(b_din), .fifo_q(fifo_q),
    .b_dout(b_dout), .b_oe(b_oe), .fifo_rd(fifo_rd),
    .mb1_idle_b(mb1_idle_b), .mb2_idle_b(mb2_idle_b));

  task automatic chk(input string req, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: pops expected mailbox words at each pending fetch edge
  always @(posedge clk_b) begin
    if (!rst_b && !b_cs_n && !b_wr_dir && b_en && b_mbox && !mb1_idle_b) begin
      if (exp_m1.size() == 0) chk("R6 unexpected fetch", b_dout, '0);
      else chk("R6 forward word", b_dout, exp_m1.pop_front());
    end
  end

  always @(posedge clk_a) begin
    if (!rst_a && !a_cs_n && !a_wr_dir && a_en && a_mbox && !mb2_idle_a) begin
      if (exp_m2.size() == 0) chk("R7 unexpected fetch", a_dout, '0);
      else chk("R7 return word", a_dout, exp_m2.pop_front());
    end
  end

  task automatic drive_a(input logic cs_n, input logic dir, input logic en,
                         input logic mb, input logic [W-1:0] d);
    @(negedge clk_a);
    a_cs_n = cs_n; a_wr_dir = dir; a_en = en; a_mbox = mb; a_din = d;
    #1;
  endtask

  task automatic drive_b(input logic cs_n, input logic dir, input logic en,
                         input logic mb, input logic [W-1:0] d);
    @(negedge clk_b);
    b_cs_n = cs_n; b_wr_dir = dir; b_en = en; b_mbox = mb; b_din = d;
    #1;
  endtask

  task automatic edge_a; @(posedge clk_a); #1; endtask
  task automatic edge_b; @(posedge clk_b); #1; endtask
  task automatic idle_a; drive_a(1'b1, 1'b0, 1'b0, 1'b0, '0); endtask
  task automatic idle_b; drive_b(1'b1, 1'b0, 1'b0, 1'b0, '0); endtask

  // Driver side of the scoreboard: push when a load should be accepted
  task automatic load_a(input logic [W-1:0] d, input bit expect_take);
    drive_a(1'b0, 1'b1, 1'b1, 1'b1, d);
    if (expect_take) exp_m1.push_back(d);
    edge_a();
    idle_a();
  endtask

  task automatic load_b(input logic [W-1:0] d, input bit expect_take);
    drive_b(1'b0, 1'b1, 1'b1, 1'b1, d);
    if (expect_take) exp_m2.push_back(d);
    edge_b();
    idle_b();
  endtask

  task automatic wait_flag_b(input string req, input bit which, input logic val,
                             input int lim);
    logic got;
    got = 1'b0;
    for (int i = 0; i < lim; i++) begin
      if ((which ? mb2_idle_b : mb1_idle_b) === val) begin got = 1'b1; break; end
      edge_b();
    end
    chk(req, {35'd0, got}, 36'd1);
  endtask

  task automatic wait_flag_a(input string req, input bit which, input logic val,
                             input int lim);
    logic got;
    got = 1'b0;
    for (int i = 0; i < lim; i++) begin
      if ((which ? mb2_idle_a : mb1_idle_a) === val) begin got = 1'b1; break; end
      edge_a();
    end
    chk(req, {35'd0, got}, 36'd1);
  endtask

  initial begin
    #(WATCHDOG * PERIOD_B);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_a = 1'b1; rst_b = 1'b1;
    a_cs_n = 1'b1; a_wr_dir = 1'b0; a_en = 1'b0; a_mbox = 1'b0; a_din = '0;
    b_cs_n = 1'b1; b_wr_dir = 1'b0; b_en = 1'b0; b_mbox = 1'b0; b_din = '0;
    fifo_q = 36'h0_F1F0_C0DE;
    repeat (4) @(posedge clk_b);
    @(negedge clk_a); rst_a = 1'b0;
    @(negedge clk_b); rst_b = 1'b0;
    edge_a();

    // R10 reset state
    chk("R10 mb1_idle_a", {35'd0, mb1_idle_a}, 36'd1);
    chk("R10 mb2_idle_a", {35'd0, mb2_idle_a}, 36'd1);
    chk("R10 mb1_idle_b", {35'd0, mb1_idle_b}, 36'd1);
    chk("R10 mb2_idle_b", {35'd0, mb2_idle_b}, 36'd1);
    chk("R10 strobes", {34'd0, fifo_wr, fifo_rd}, 36'd0);

    // R1 select high blocks everything
    drive_a(1'b1, 1'b1, 1'b1, 1'b0, 36'h1);
    chk("R1 fifo_wr", {35'd0, fifo_wr}, 36'd0);
    chk("R1 a_oe/a_dout", {a_oe, a_dout[W-2:0]}, 36'd0);
    drive_a(1'b1, 1'b1, 1'b1, 1'b1, 36'h2);
    edge_a();
    chk("R1 mb1_idle_a", {35'd0, mb1_idle_a}, 36'd1);
    idle_a();

    // R2 FIFO write strobe and data
    drive_a(1'b0, 1'b1, 1'b1, 1'b0, 36'h9_ABCD_1234);
    chk("R2 fifo_wr", {35'd0, fifo_wr}, 36'd1);
    chk("R2 fifo_wdata", fifo_wdata, 36'h9_ABCD_1234);
    chk("R2 a_oe", {35'd0, a_oe}, 36'd0);
    idle_a();

    // R12 unmapped combinations
    drive_a(1'b0, 1'b0, 1'b1, 1'b0, 36'h3);
    chk("R12 port A read no strobe", {35'd0, fifo_wr}, 36'd0);
    chk("R7 a_oe on read dir", {35'd0, a_oe}, 36'd1);
    idle_a();
    drive_b(1'b0, 1'b1, 1'b1, 1'b0, 36'h4);
    chk("R12 port B write no strobe", {35'd0, fifo_rd}, 36'd0);
    chk("R2 b_oe on write dir", {35'd0, b_oe}, 36'd0);
    idle_b();

    // R8 enable low
    drive_a(1'b0, 1'b1, 1'b0, 1'b0, 36'h5);
    chk("R8 fifo_wr", {35'd0, fifo_wr}, 36'd0);
    drive_a(1'b0, 1'b1, 1'b0, 1'b1, 36'h6);
    edge_a();
    chk("R8 no load", {35'd0, mb1_idle_a}, 36'd1);
    idle_a();
    drive_b(1'b0, 1'b0, 1'b0, 1'b0, '0);
    chk("R8 fifo_rd", {35'd0, fifo_rd}, 36'd0);

    // R4 / R5 FIFO read path
    drive_b(1'b0, 1'b0, 1'b1, 1'b0, '0);
    chk("R5 fifo_rd", {35'd0, fifo_rd}, 36'd1);
    chk("R4 b_oe", {35'd0, b_oe}, 36'd1);
    chk("R4 b_dout fifo", b_dout, 36'h0_F1F0_C0DE);
    idle_b();

    // R11 fetch of empty mailbox
    drive_b(1'b0, 1'b0, 1'b1, 1'b1, '0);
    edge_b();
    idle_b();
    repeat (6) edge_a();
    chk("R11 mb1_idle_b", {35'd0, mb1_idle_b}, 36'd1);
    chk("R11 mb1_idle_a", {35'd0, mb1_idle_a}, 36'd1);

    // R3 load forward mailbox
    load_a(36'hA_5555_0001, 1'b1);
    chk("R3 writer flag low", {35'd0, mb1_idle_a}, 36'd0);
    wait_flag_b("R3 reader flag low", 1'b0, 1'b0, 4);

    // R9 second load ignored
    load_a(36'hB_6666_0002, 1'b0);
    chk("R9 writer flag still low", {35'd0, mb1_idle_a}, 36'd0);

    // R4 bus shows mailbox word without fetching
    drive_b(1'b0, 1'b0, 1'b0, 1'b1, '0);
    chk("R4 b_dout mailbox", b_dout, 36'hA_5555_0001);
    edge_b();
    chk("R6 flag holds w/o fetch", {35'd0, mb1_idle_b}, 36'd0);

    // R6 fetch
    drive_b(1'b0, 1'b0, 1'b1, 1'b1, '0);
    edge_b();
    chk("R6 reader flag high", {35'd0, mb1_idle_b}, 36'd1);
    idle_b();
    wait_flag_a("R6 writer flag high", 1'b0, 1'b1, 12);

    // R3 reload after round trip
    load_a(36'hC_7777_0003, 1'b1);
    wait_flag_b("R3 reload reader low", 1'b0, 1'b0, 4);
    drive_b(1'b0, 1'b0, 1'b1, 1'b1, '0);
    edge_b();
    idle_b();
    wait_flag_a("R6 second round writer high", 1'b0, 1'b1, 12);

    // R7 return mailbox
    load_b(36'hD_8888_0004, 1'b1);
    chk("R7 writer flag low", {35'd0, mb2_idle_b}, 36'd0);
    wait_flag_a("R7 reader flag low", 1'b1, 1'b0, 4);
    load_b(36'hE_9999_0005, 1'b0);
    chk("R9 return load ignored", {35'd0, mb2_idle_b}, 36'd0);
    drive_a(1'b0, 1'b0, 1'b0, 1'b1, '0);
    chk("R7 a_dout", a_dout, 36'hD_8888_0004);
    drive_a(1'b0, 1'b0, 1'b1, 1'b1, '0);
    edge_a();
    chk("R7 reader flag high", {35'd0, mb2_idle_a}, 36'd1);
    idle_a();
    wait_flag_b("R7 writer flag high", 1'b1, 1'b1, 12);

    repeat (3) edge_b();
    chk("R6 queue drained", {30'd0, exp_m1.size()[5:0]}, 36'd0);
    chk("R7 queue drained", {30'd0, exp_m2.size()[5:0]}, 36'd0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule